// File: doc/BRIEF.md
# Oscillator Start-Up Delay Timer

This block tells software when a main crystal oscillator can be trusted. Software writes one configuration word that carries an enable bit and an 8-bit start-up count. Once the enable is set, a timer in the slow-clock domain waits eight slow-clock cycles for each unit of the count and then raises a stable flag. The flag is brought back into the bus clock domain through a two-flop synchroniser. Software sees it either as a status output it can poll or as a level interrupt, which is gated by an interrupt-enable bit.

The enable bit crosses into the slow domain through its own two-flop synchroniser. The count field is quasi-static: software must not change it while the enable is set. Clearing the enable drops the visible status at once, and the slow-domain counter restarts from zero the next time the enable is set. The interrupt-enable bit has separate set and clear strobes.

Top module: `osc_startup_timer`

## Requirements
- R1: After reset, the configuration readback, the status output, the interrupt-enable output and the interrupt output are all 0.
- R2: A write strobe loads the enable from bit 0 and the start-up count from bits 15:8 of the write data. The readback returns these fields at the same bit positions, and every other readback bit is 0.
- R3: For a count N with N > 0, the stable flag is set on the 8×N-th slow-clock edge after the slow-clock edge that registers the enable at the output of its two-flop synchroniser. The status becomes visible two bus-clock edges later. Measured from the write, the status first reads 1 after slow edge 8×N+2.
- R4: For a count of 0, the stable flag is set on the first slow-clock edge after the synchronised enable is seen, so the status first reads 1 after slow edge 3 following the write.
- R5: A write that clears the enable forces the status output and the interrupt output to 0 from the next bus-clock edge. A later enable restarts the full delay from zero.
- R6: While the enable stays set, the status stays 1 once it has been set.
- R7: The interrupt output equals the status output ANDed with the interrupt-enable bit.
- R8: A set strobe makes the interrupt-enable bit 1, and a clear strobe makes it 0. When both strobes arrive in the same cycle, the clear wins.
- R9: The largest count, 255, gives a delay of 2040 slow-clock edges, with no wrap of the internal counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus-side clock |
| prst_n | input | 1 | Synchronous active-low reset, bus domain |
| sclk | input | 1 | Slow clock that times the start-up |
| srst_n | input | 1 | Synchronous active-low reset, slow domain |
| wr_cfg | input | 1 | Write strobe for the configuration word |
| wdata | input | 16 | Configuration write data: bit 0 is the enable, bits 15:8 are the count |
| ie_set | input | 1 | Strobe that sets the interrupt-enable bit |
| ie_clr | input | 1 | Strobe that clears the interrupt-enable bit (wins over a set) |
| rd_cfg | output | 16 | Configuration readback |
| sts_o | output | 1 | Synchronised oscillator-stable status |
| ie_o | output | 1 | Current interrupt-enable bit |
| irq_o | output | 1 | Level interrupt: status AND interrupt enable |

## Verification
The bench counts slow-clock edges from each enabling write until the status appears, and compares the count with the value expected for counts 0, 1, 7 and 255. A prescaler that is off by one, or a count of zero handled as a full wrap, shows up as a wrong edge count; for zero, a wrap would hang until the timeout. The bench clears the enable and checks that the status drops in the very next bus cycle, then re-enables and checks that the full delay repeats; a counter that is not reset would finish early. It also drives both interrupt-enable strobes in the same cycle. A design that gave priority to the set would leave the interrupt asserted.

// File: rtl/osu_pkg.sv
// Package: shared field layout for the oscillator start-up timer.
// Assumes the configuration word is 16 bits wide, with the enable at bit 0
// and the count in the top byte.
package osu_pkg;
    localparam int CFG_W   = 16;
    localparam int CNT_W   = 8;
    localparam int PRE_W   = 3;   // prescale by 2**PRE_W = 8 slow cycles per unit
    localparam int EN_BIT  = 0;
    localparam int CNT_LSB = 8;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/osu_sync.sv
// Module: multi-stage single-bit synchroniser.
// Assumes the input is a level that stays stable for several destination
// cycles. The reset is synchronous, active-low, to the destination clock.
module osu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/osu_timer.sv
// Module: slow-clock start-up counter.
// A prescaler of 2**PRE_W slow cycles feeds a unit counter. While en_i is
// high, the stable flag is set on slow edge 2**PRE_W * cnt_i, counting from
// the first edge that samples en_i high (edge 1 when cnt_i is 0).
// Assumes cnt_i is held steady while en_i is high. en_i is already
// synchronised to sclk.
module osu_timer #(
    parameter int CNT_W = osu_pkg::CNT_W,
    parameter int PRE_W = osu_pkg::PRE_W
) (
    input  logic             sclk,
    input  logic             srst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             stable_o
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] unit_q;
    logic             stable_q;
    logic             done_now;

    // The delay ends now when the count is zero, or on the last prescale tick of the final unit.
    always_comb begin
        done_now = (cnt_i == '0) ||
                   ((pre_q == PRE_LAST) && (unit_q == CNT_W'(cnt_i - 1'b1)));
    end

    // Advance the prescaler and the unit counter, and set the flag once the delay ends.
    always_ff @(posedge sclk) begin
        if (!srst_n || !en_i) begin
            pre_q    <= '0;
            unit_q   <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            if (done_now) begin
                stable_q <= 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
                if (pre_q == PRE_LAST) unit_q <= unit_q + 1'b1;
            end
        end
    end

    assign stable_o = stable_q;

    AST_STABLE_NEEDS_EN: assert property (@(posedge sclk) disable iff (!srst_n)
        !en_i |=> !stable_q);                                   // R5
    AST_STABLE_HOLDS: assert property (@(posedge sclk) disable iff (!srst_n)
        (stable_q && en_i) |=> stable_q);                       // R6
    AST_NO_UNIT_OVERFLOW: assert property (@(posedge sclk) disable iff (!srst_n)
        (en_i && !stable_q && cnt_i != '0) |-> (unit_q < cnt_i)); // R9
endmodule

// File: rtl/osu_regs.sv
// Module: bus-side configuration, interrupt-enable and status logic.
// Holds the enable and the count, and handles the interrupt-enable strobes
// (a clear wins over a set). It gates the synchronised stable flag with the
// enable, so that clearing the enable drops the status at once.
// Assumes stable_sync_i has already passed through a synchroniser on pclk.
module osu_regs #(
    parameter int CFG_W   = osu_pkg::CFG_W,
    parameter int CNT_W   = osu_pkg::CNT_W,
    parameter int EN_BIT  = osu_pkg::EN_BIT,
    parameter int CNT_LSB = osu_pkg::CNT_LSB
) (
    input  logic             pclk,
    input  logic             prst_n,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wdata,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             stable_sync_i,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CFG_W-1:0] rd_cfg,
    output logic             sts_o,
    output logic             ie_o,
    output logic             irq_o
);
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ie_q;
    logic             unused_wbits;

    // Capture the configuration fields on a write strobe.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (wr_cfg) begin
            en_q  <= wdata[EN_BIT];
            cnt_q <= wdata[CNT_LSB +: CNT_W];
        end
    end

    // Update the interrupt enable; a clear strobe has priority over a set strobe.
    always_ff @(posedge pclk) begin
        if (!prst_n)     ie_q <= 1'b0;
        else if (ie_clr) ie_q <= 1'b0;
        else if (ie_set) ie_q <= 1'b1;
    end

    // Assemble the readback word; the bits without a field read as zero.
    always_comb begin
        rd_cfg                    = '0;
        rd_cfg[EN_BIT]            = en_q;
        rd_cfg[CNT_LSB +: CNT_W]  = cnt_q;
    end

    assign unused_wbits = ^wdata;
    assign en_o  = en_q;
    assign cnt_o = cnt_q;
    assign sts_o = en_q & stable_sync_i;
    assign ie_o  = ie_q;
    assign irq_o = ie_q & sts_o;

    AST_IE_CLR_WINS: assert property (@(posedge pclk) disable iff (!prst_n)
        ie_clr |=> !ie_q);                                      // R8
    AST_IE_SET: assert property (@(posedge pclk) disable iff (!prst_n)
        (ie_set && !ie_clr) |=> ie_q);                          // R8
    AST_STS_DROP: assert property (@(posedge pclk) disable iff (!prst_n)
        (wr_cfg && !wdata[EN_BIT]) |=> (!sts_o && !irq_o));     // R5
endmodule

// File: rtl/osc_startup_timer.sv
// Module: top of the oscillator start-up delay timer.
// Connects the bus-side registers, the two synchronisers and the slow-clock
// timer. The two resets are synchronous and active-low, one for each clock.
// Assumes the count is not rewritten while the enable is set.
module osc_startup_timer #(
    parameter int CFG_W   = osu_pkg::CFG_W,
    parameter int CNT_W   = osu_pkg::CNT_W,
    parameter int PRE_W   = osu_pkg::PRE_W,
    parameter int STAGES  = osu_pkg::SYNC_STAGES
) (
    input  logic             pclk,
    input  logic             prst_n,
    input  logic             sclk,
    input  logic             srst_n,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wdata,
    input  logic             ie_set,
    input  logic             ie_clr,
    output logic [CFG_W-1:0] rd_cfg,
    output logic             sts_o,
    output logic             ie_o,
    output logic             irq_o
);
    logic             en_p;
    logic [CNT_W-1:0] cnt_p;
    logic             en_s;
    logic             stable_s;
    logic             stable_p;

    osu_regs #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_regs (
        .pclk(pclk), .prst_n(prst_n), .wr_cfg(wr_cfg), .wdata(wdata),
        .ie_set(ie_set), .ie_clr(ie_clr), .stable_sync_i(stable_p),
        .en_o(en_p), .cnt_o(cnt_p), .rd_cfg(rd_cfg),
        .sts_o(sts_o), .ie_o(ie_o), .irq_o(irq_o)
    );

    osu_sync #(.STAGES(STAGES)) u_en_sync (
        .clk(sclk), .rst_n(srst_n), .d_i(en_p), .q_o(en_s)
    );

    osu_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
        .sclk(sclk), .srst_n(srst_n), .en_i(en_s), .cnt_i(cnt_p),
        .stable_o(stable_s)
    );

    osu_sync #(.STAGES(STAGES)) u_sts_sync (
        .clk(pclk), .rst_n(prst_n), .d_i(stable_s), .q_o(stable_p)
    );
endmodule

// File: tb/osc_startup_timer_bench.sv
// Scoreboard bench: drivers push expected values, and the monitor pops and compares them.
module osc_startup_timer_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_PERIOD = 80;
    localparam int WATCHDOG    = 150000;

    logic        pclk = 1'b0, sclk = 1'b0;
    logic        prst_n = 1'b0, srst_n = 1'b0;
    logic        wr_cfg = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_cfg;
    logic        sts_o, ie_o, irq_o;

    int checks = 0, failures = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    osc_startup_timer u_osc_startup_timer (
        .pclk(pclk), .prst_n(prst_n), .sclk(sclk), .srst_n(srst_n),
        .wr_cfg(wr_cfg), .wdata(wdata), .ie_set(ie_set), .ie_clr(ie_clr),
        .rd_cfg(rd_cfg), .sts_o(sts_o), .ie_o(ie_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;
    initial begin #2; forever #(SCLK_PERIOD/2) sclk = ~sclk; end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_exp(string req, int v);
        tag_q.push_back(req);
        exp_q.push_back(v);
    endtask

    // Monitor: compare one observed value with the oldest expected item.
    task automatic monitor_pop(int act);
        string req = tag_q.pop_front();
        int    exp = exp_q.pop_front();
        check(req, act, exp);
    endtask

    task automatic bus_write(logic [15:0] d);
        @(negedge pclk); wr_cfg = 1'b1; wdata = d;
        @(negedge pclk); wr_cfg = 1'b0; wdata = '0;
    endtask

    task automatic ie_strobe(logic s, logic c);
        @(negedge pclk); ie_set = s; ie_clr = c;
        @(negedge pclk); ie_set = 1'b0; ie_clr = 1'b0;
    endtask

    // Driver: enable with count n, push the expected edge count, then measure it.
    task automatic startup(string req, int n);
        int k = 0;
        int limit = 8 * n + 30;
        push_exp(req, (n == 0) ? 3 : 8 * n + 2);
        bus_write({n[7:0], 8'h01});
        while (k < limit) begin
            @(posedge sclk); k++;
            repeat (3) @(posedge pclk);
            #1;
            if (sts_o) break;
        end
        monitor_pop(sts_o ? k : -1);
    endtask

    task automatic disable_and_idle();
        bus_write(16'h0000);
        repeat (4) @(posedge sclk);
        @(negedge pclk);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge sclk);
        @(negedge pclk); prst_n = 1'b1; srst_n = 1'b1;
        @(negedge pclk);
        // R1 reset state
        check("R1 rd_cfg", rd_cfg, 0);
        check("R1 sts", sts_o, 0);
        check("R1 ie", ie_o, 0);
        check("R1 irq", irq_o, 0);
        // R2 field placement and readback
        bus_write(16'h00F7);
        check("R2 readback en only", rd_cfg, 16'h0001);
        bus_write(16'h3CFE);
        check("R2 readback count only", rd_cfg, 16'h3C00);
        repeat (6) @(posedge sclk); @(negedge pclk);
        check("R2 disabled status stays low", sts_o, 0);
        // R3 count 7
        startup("R3 count7 delay", 7);
        repeat (5) @(posedge sclk); @(negedge pclk);
        check("R6 status holds", sts_o, 1);
        // R7 / R8 interrupt gating and strobes
        check("R7 irq masked", irq_o, 0);
        ie_strobe(1'b1, 1'b0);
        check("R8 ie set", ie_o, 1);
        check("R7 irq on", irq_o, 1);
        ie_strobe(1'b1, 1'b1);
        check("R8 clear wins", ie_o, 0);
        check("R7 irq off after clear", irq_o, 0);
        ie_strobe(1'b1, 1'b0);
        check("R7 irq re-armed", irq_o, 1);
        // R5 clearing the enable drops status and irq at once
        bus_write(16'h0700);
        check("R5 sts drop", sts_o, 0);
        check("R5 irq drop", irq_o, 0);
        repeat (4) @(posedge sclk);
        startup("R5 restart full delay", 7);
        disable_and_idle();
        // R4 count 0
        startup("R4 count0 delay", 0);
        disable_and_idle();
        // R3 count 1
        startup("R3 count1 delay", 1);
        disable_and_idle();
        // R9 largest count
        startup("R9 count255 delay", 255);
        check("R9 irq with max count", irq_o, 1);
        disable_and_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule